// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This block produces the bit timing for a CAN node. One 8-bit configuration register holds two fields: a prescaler value and a jump-width value. The prescaler divides the input clock into time-quantum ticks. A bit-time state machine then walks through a one-quantum sync segment, a first phase segment and a second phase segment. It pulses a sample strobe where the receive line should be read, and a bit-boundary strobe where the bit ends. The lengths of the two phase segments come in on input ports, and each is measured in quanta.

Falling (recessive-to-dominant) edges of the receive input are synchronized first. When the bus is busy, an edge lets the unit correct its phase. An edge that comes late, while the first phase segment is running, stretches that segment. An edge that comes early, while the second phase segment is running, cuts that segment short. The correction is never more than the jump width. When the bus is idle, a falling edge hard-synchronizes the unit: the bit restarts at the sync segment, with no limit.

Frame decoding, bit stuffing, arbitration and error handling belong to other blocks. Those blocks use the two strobes.

Top module: `can_bit_timer`

## Requirements
- R1: The configuration register resets to 0x00. Bits 5:0 are the prescaler value and bits 7:6 are the jump-width field. A write pulse updates the register only while the configuration-enable input is high. Otherwise the write is ignored, and the register can always be read on its read-back port.
- R2: The quantum tick is a single-cycle pulse. Ticks are spaced 2 × (prescaler + 1) clock cycles apart, for every prescaler value from 0 to 63. With a 50 ns clock, prescaler 3 gives 400 ns (8 clocks) and prescaler 1 gives 200 ns (4 clocks).
- R3: With no receive edges, a bit lasts 1 + phase-1 + phase-2 quanta. The sample strobe is a single cycle on the tick that ends phase 1. The bit-boundary strobe is a single cycle on the tick that ends phase 2. The two strobes never occur in the same cycle.
- R4: The effective jump width is the field value plus one. An edge in phase 1 has a phase error equal to the number of phase-1 quanta elapsed, counting the current quantum. Phase 1 is lengthened by the smaller of that error and the jump width.
- R5: An edge in phase 2 has a phase error equal to the number of phase-2 quanta left, counting the current quantum. Phase 2 is shortened by the smaller of that error and the jump width, and the bit ends no earlier than the tick of the current quantum.
- R6: A falling edge during the sync segment makes no adjustment.
- R7: Only one resynchronization is applied in a bit time. Further falling edges in the same bit have no effect.
- R8: While bus-idle is high, a falling edge restarts the bit at the sync segment and restarts the quantum count. The jump width does not limit this. The next sample strobe comes 1 + phase-1 quanta after the restart.
- R9: Reset clears the prescaler count and puts the state machine in the sync segment. No strobe is asserted before the first quantum tick, and that tick comes a fixed number of cycles after reset is released.
- R10: The receive input passes through a two-flop synchronizer. Rising (dominant-to-recessive) edges cause no adjustment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_en | input | 1 | Configuration enable; write pulses take effect only while high |
| cfg_we | input | 1 | Single-cycle write pulse for the configuration register |
| cfg_wdata | input | 8 | Write data: bits 7:6 jump-width field, bits 5:0 prescaler |
| cfg_rdata | output | 8 | Current configuration register contents |
| ph1_len | input | 5 | Phase segment 1 length in quanta, at least 1 |
| ph2_len | input | 5 | Phase segment 2 length in quanta, at least 1 |
| rx_in | input | 1 | Receive line, asynchronous, 1 = recessive |
| bus_idle | input | 1 | High while the bus is idle; selects hard sync on a falling edge |
| tq_tick | output | 1 | Single-cycle pulse at the end of each time quantum |
| sample_pt | output | 1 | Single-cycle sample strobe at the end of phase segment 1 |
| bit_end | output | 1 | Single-cycle strobe at the end of phase segment 2 |

## Verification
Free-running timing is measured under five different pairs of prescaler value and segment lengths. The prescaler values include 0, 1, 3 and 63. This separates an error in the quantum length from an error in the segment counts. Falling edges are placed at chosen quanta of a bit: inside the sync segment, early and late in phase 1, and at the start of phase 2. Three jump-width settings are used. Together these show whether the bit is clamped at the jump width or follows the phase error, and whether phase 1 is stretched or phase 2 shortened. A second edge in the same bit shows whether the one-correction-per-bit rule holds. A hard-sync edge in the middle of phase 1 shows whether the bit really restarts.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  localparam int BT_BRP_W = 6;
  localparam int BT_SJW_W = 2;
  localparam int BT_SEG_W = 5;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } bt_seg_e;

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int BRP_W = can_bt_pkg::BT_BRP_W,
  parameter int SJW_W = can_bt_pkg::BT_SJW_W,
  localparam int CFG_W = BRP_W + SJW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [BRP_W-1:0] brp,
  output logic [SJW_W:0]   sjw_eff
);

  localparam logic [SJW_W:0] SJW_ONE = 1;

  logic             wr_en;
  logic [CFG_W-1:0] cfg_d;

  // register is locked unless the enable input is held high
  assign wr_en = cfg_en & cfg_we;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign brp     = cfg_q[BRP_W-1:0];
  assign sjw_eff = {1'b0, cfg_q[CFG_W-1:BRP_W]} + SJW_ONE;

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int BRP_W = can_bt_pkg::BT_BRP_W,
  localparam int CNT_W = BRP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] brp,
  input  logic             restart,
  output logic             tick
);

  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             wrap;

  // 2*(brp+1) clocks per quantum: count 0 .. 2*brp+1
  assign lim  = {brp, 1'b1};
  assign wrap = (cnt_q >= lim);
  assign tick = wrap & ~restart;

  always_comb begin
    cnt_d = cnt_q + CNT_ONE;
    if (restart || wrap) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/can_bt_rxedge.sv
module can_bt_rxedge #(
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic fall
);

  // SYNC_STG synchronizer flops plus one history flop
  logic [SYNC_STG:0] sh_q, sh_d;

  assign sh_d = {sh_q[SYNC_STG-1:0], rx_in};
  assign fall = sh_q[SYNC_STG] & ~sh_q[SYNC_STG-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG_W = can_bt_pkg::BT_SEG_W,
  parameter int SJW_W = can_bt_pkg::BT_SJW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fall,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W:0]   sjw_eff,
  output bt_seg_e          seg,
  output logic             hsync,
  output logic             sample_pt,
  output logic             bit_end
);

  localparam int CNT_W = SEG_W + 1;
  localparam logic [CNT_W-1:0] Q_ONE = 1;

  bt_seg_e          seg_q, seg_d;
  logic [CNT_W-1:0] qcnt_q, qcnt_d;
  logic [CNT_W-1:0] adj_q, adj_d;
  logic             done_q, done_d;
  logic             upd;

  logic [CNT_W-1:0] ph1_x, ph2_x, sjw_x, qnext;
  logic [CNT_W-1:0] err, adj_new, adj_use, len_eff;
  logic             rsync, seg_last;

  assign ph1_x = {1'b0, ph1_len};
  assign ph2_x = {1'b0, ph2_len};
  assign sjw_x = CNT_W'(sjw_eff);
  assign qnext = qcnt_q + Q_ONE;

  // phase error and the limited correction
  always_comb begin
    hsync = fall & bus_idle;
    rsync = fall & ~bus_idle & ~done_q & (seg_q != SEG_SYNC);
    err   = '0;
    case (seg_q)
      SEG_PH1: err = qnext;
      SEG_PH2: err = (ph2_x > qcnt_q) ? (ph2_x - qcnt_q) : '0;
      default: err = '0;
    endcase
    adj_new = (err < sjw_x) ? err : sjw_x;
    adj_use = rsync ? adj_new : adj_q;
  end

  // effective segment length and end-of-segment decode
  always_comb begin
    case (seg_q)
      SEG_PH1: len_eff = ph1_x + adj_use;
      SEG_PH2: len_eff = (ph2_x > adj_use) ? (ph2_x - adj_use) : '0;
      default: len_eff = Q_ONE;
    endcase
    seg_last  = (qnext >= len_eff);
    sample_pt = tick & ~hsync & (seg_q == SEG_PH1) & seg_last;
    bit_end   = tick & ~hsync & (seg_q == SEG_PH2) & seg_last;
  end

  // next state
  always_comb begin
    seg_d  = seg_q;
    qcnt_d = qcnt_q;
    adj_d  = adj_q;
    done_d = done_q;
    if (hsync) begin
      seg_d  = SEG_SYNC;
      qcnt_d = '0;
      adj_d  = '0;
      done_d = 1'b1;
    end else begin
      if (rsync) begin
        adj_d  = adj_new;
        done_d = 1'b1;
      end
      if (tick) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_d  = SEG_PH1;
            qcnt_d = '0;
            adj_d  = '0;
          end
          SEG_PH1: begin
            if (seg_last) begin
              seg_d  = SEG_PH2;
              qcnt_d = '0;
              adj_d  = '0;
            end else begin
              qcnt_d = qnext;
            end
          end
          SEG_PH2: begin
            if (seg_last) begin
              seg_d  = SEG_SYNC;
              qcnt_d = '0;
              adj_d  = '0;
              done_d = 1'b0;
            end else begin
              qcnt_d = qnext;
            end
          end
          default: begin
            seg_d  = SEG_SYNC;
            qcnt_d = '0;
            adj_d  = '0;
          end
        endcase
      end
    end
  end

  assign upd = hsync | rsync | tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      qcnt_q <= '0;
      adj_q  <= '0;
      done_q <= 1'b0;
    end else if (upd) begin
      seg_q  <= seg_d;
      qcnt_q <= qcnt_d;
      adj_q  <= adj_d;
      done_q <= done_d;
    end
  end

  assign seg = seg_q;

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W    = BT_BRP_W,
  parameter int SJW_W    = BT_SJW_W,
  parameter int SEG_W    = BT_SEG_W,
  parameter int SYNC_STG = 2,
  localparam int CFG_W   = BRP_W + SJW_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic             rx_in,
  input  logic             bus_idle,
  output logic             tq_tick,
  output logic             sample_pt,
  output logic             bit_end
);

  logic [1:0]       rst_sh_q;
  logic             rst_sync_n;
  logic [BRP_W-1:0] brp;
  logic [SJW_W:0]   sjw_eff;
  logic             fall;
  logic             hsync;
  bt_seg_e          seg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sh_q[1];

  can_bt_cfg #(.BRP_W(BRP_W), .SJW_W(SJW_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_q(cfg_rdata), .brp(brp), .sjw_eff(sjw_eff)
  );

  can_bt_presc #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_sync_n), .brp(brp), .restart(hsync), .tick(tq_tick)
  );

  can_bt_rxedge #(.SYNC_STG(SYNC_STG)) u_rxedge (
    .clk(clk), .rst_n(rst_sync_n), .rx_in(rx_in), .fall(fall)
  );

  can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .tick(tq_tick), .fall(fall),
    .bus_idle(bus_idle), .ph1_len(ph1_len), .ph2_len(ph2_len),
    .sjw_eff(sjw_eff), .seg(seg), .hsync(hsync),
    .sample_pt(sample_pt), .bit_end(bit_end)
  );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
  import can_bt_pkg::*;
#(
  parameter int CFG_W = BT_BRP_W + BT_SJW_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_en,
  input logic             cfg_we,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             tq_tick,
  input logic             sample_pt,
  input logic             bit_end,
  input logic             hsync,
  input bt_seg_e          seg
);

  p_cfg_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_en && cfg_we) |=> $stable(cfg_rdata));

  p_tick_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tq_tick |=> !tq_tick);

  p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> tq_tick);

  p_end_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> tq_tick);

  p_strobes_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && bit_end));

  p_end_to_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |=> (seg == SEG_SYNC));

  p_hsync_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> (seg == SEG_SYNC) && !tq_tick);

endmodule

bind can_bit_timer can_bit_timer_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
  .cfg_rdata(cfg_rdata), .tq_tick(tq_tick), .sample_pt(sample_pt),
  .bit_end(bit_end), .hsync(hsync), .seg(seg)
);

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n, cfg_en, cfg_we, rx_in, bus_idle;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic [4:0] ph1_len, ph2_len;
  logic       tq_tick, sample_pt, bit_end;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .rx_in(rx_in), .bus_idle(bus_idle),
    .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end)
  );

  // free-running timing vectors: prescaler, phase 1, phase 2 -> tick period, sample offset, bit length
  localparam int NV = 5;
  localparam int V_BRP [NV] = '{0, 1, 3, 63, 2};
  localparam int V_P1  [NV] = '{4, 2, 3, 1, 8};
  localparam int V_P2  [NV] = '{3, 2, 2, 1, 5};
  localparam int V_TQ  [NV] = '{2, 4, 8, 128, 6};
  localparam int V_SMP [NV] = '{10, 12, 32, 256, 54};
  localparam int V_BIT [NV] = '{16, 20, 48, 384, 84};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic en, input logic [7:0] d);
    @(negedge clk);
    cfg_en = en; cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_en = 1'b0;
  endtask

  task automatic wait_end();
    do @(negedge clk); while (!bit_end);
  endtask

  task automatic tick_period(output int p);
    do @(negedge clk); while (!tq_tick);
    p = 0;
    do begin @(negedge clk); p++; end while (!tq_tick);
  endtask

  // after a bit boundary, drive falling edges at cycle offsets d1/d2, report strobe offsets
  task automatic edge_run(input int d1, input int d2, output int s, output int b);
    int c;
    wait_end();
    c = 0; s = -1; b = -1;
    if (d1 == 0) rx_in = 1'b0;
    while (b < 0) begin
      @(negedge clk);
      c++;
      if (c == d1)     rx_in = 1'b0;
      if (c == d1 + 3) rx_in = 1'b1;
      if (c == d2)     rx_in = 1'b0;
      if (c == d2 + 3) rx_in = 1'b1;
      if (sample_pt && s < 0) s = c;
      if (bit_end) b = c;
    end
    rx_in = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int s, b, p, c, strobes;
    rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00;
    rx_in = 1'b1; bus_idle = 1'b0; ph1_len = 5'd4; ph2_len = 5'd3;

    // R9 / R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 reset cfg", int'(cfg_rdata), 0);
    chk("R9 strobes in reset", int'({tq_tick, sample_pt, bit_end}), 0);
    rst_n = 1'b1;
    c = 0; strobes = 0;
    do begin
      @(negedge clk); c++;
      strobes += int'(sample_pt) + int'(bit_end);
    end while (!tq_tick && c < 50);
    chk("R9 first tick offset", c, 3);
    chk("R9 no strobe before first tick", strobes, 0);

    // R2 / R3: vector table
    for (int i = 0; i < NV; i++) begin
      ph1_len = 5'(V_P1[i]); ph2_len = 5'(V_P2[i]);
      wr_cfg(1'b1, {2'b01, 6'(V_BRP[i])});
      chk("R1 cfg written", int'(cfg_rdata), 64 + V_BRP[i]);
      tick_period(p);
      chk("R2 quantum length", p, V_TQ[i]);
      wait_end();
      edge_run(1000, 1000, s, b);
      chk("R3 sample offset", s, V_SMP[i]);
      chk("R3 bit length", b, V_BIT[i]);
    end

    // R1: writes locked without enable (config now 0x42)
    wr_cfg(1'b0, 8'hFF);
    chk("R1 locked write ignored", int'(cfg_rdata), 8'h42);
    tick_period(p);
    chk("R1 locked quantum unchanged", p, 6);
    wr_cfg(1'b1, 8'h40);
    chk("R1 enabled write", int'(cfg_rdata), 8'h40);
    ph1_len = 5'd4; ph2_len = 5'd3;
    wait_end();

    // jump width 2 (field 1), quantum 2 clocks, bit 1+4+3
    edge_run(5, 1000, s, b);
    chk("R4 late edge clamped sample", s, 14);
    chk("R4 late edge clamped bit", b, 20);
    edge_run(1, 1000, s, b);
    chk("R4 small error sample", s, 12);
    chk("R4 small error bit", b, 18);
    edge_run(9, 1000, s, b);
    chk("R5 early edge sample", s, 10);
    chk("R5 early edge bit", b, 12);
    edge_run(0, 1000, s, b);
    chk("R6 sync edge sample", s, 10);
    chk("R6 R10 sync edge and rise bit", b, 16);
    edge_run(5, 13, s, b);
    chk("R7 second edge sample", s, 14);
    chk("R7 second edge ignored bit", b, 20);

    // jump width 1 (field 0)
    wr_cfg(1'b1, 8'h00);
    edge_run(9, 1000, s, b);
    chk("R5 sjw1 shorten bit", b, 14);

    // jump width 4 (field 3)
    wr_cfg(1'b1, 8'hC0);
    edge_run(9, 1000, s, b);
    chk("R5 sjw4 shorten bit", b, 12);
    edge_run(5, 1000, s, b);
    chk("R4 sjw4 error-limited sample", s, 16);
    chk("R4 sjw4 error-limited bit", b, 22);

    // R8: hard sync in the middle of phase 1
    wr_cfg(1'b1, 8'h40);
    wait_end();
    repeat (7) @(negedge clk);
    bus_idle = 1'b1; rx_in = 1'b0;
    c = 0; s = -1; b = -1;
    while (b < 0 && c < 200) begin
      @(negedge clk); c++;
      if (c == 3) rx_in = 1'b1;
      if (sample_pt && s < 0) s = c;
      if (bit_end) b = c;
    end
    bus_idle = 1'b0;
    chk("R8 hard sync sample", s, 12);
    chk("R8 hard sync bit", b, 18);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule